// File: doc/BRIEF.md
# MII Management Register Slave

This block is the PHY-side endpoint of the two-wire MII management bus. It samples the management clock and data line with the system clock. It decodes serial read and write frames and accepts only frames whose PHY address matches a strapped address. It then serves a small register space: control, status, two identifier words, advertisement, link partner ability, expansion, a vendor status word, a vendor control word, and six saturating error-event counters. The datapath sends one-cycle strobes to the counters.

The control register drives the PHY's mode outputs: soft reset, loopback, speed, auto-negotiation enable, power-down, isolate and duplex. A strap selects between adapter mode and repeater mode. In adapter mode only a four-address window is reachable. In repeater mode the full 5-bit address space is reachable. A vendor control bit lets frames be accepted without the long preamble.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is, in this order: a start pattern of 0 then 1, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first. The opcode 10 means read and 01 means write. The opcodes 00 and 11 cause no register access and no drive of the line.
- R2: On an accepted read, `mdio_oe` stays low during the first turnaround bit. During the second turnaround bit the block drives 0. It then presents the register value MSB first, one bit per MDC period, and releases `mdio_oe` after the last data bit.
- R3: When `repeater_mode`=0, the block responds only to PHY address {000, `phy_addr_strap`[1:0]}. When `repeater_mode`=1, it responds only to PHY address `phy_addr_strap`.
- R4: When register 17 bit 0 is clear, a start pattern is honoured only after at least 32 consecutive 1 bits. When that bit is set, frames with no preamble are accepted. Only bit 0 of register 17 is writable; its other bits read 0.
- R5: Register 0 holds loopback (bit 14), speed 100 (bit 13), auto-negotiation enable (bit 12), power-down (bit 11), isolate (bit 10) and full duplex (bit 8). These bits are writable and drive the matching `ctl_*` outputs. Register 0 resets to 0x3000, and its other bits read 0.
- R6: Writing register 0 with bit 15 set raises `ctl_soft_reset` for SRST_CYCLES clocks (16 by default), and bit 15 reads 1 during that time. The write returns registers 0 and 4 to their reset values and leaves register 17 unchanged. During the soft reset the `ctl_*` mode outputs show the defaults.
- R7: The read-only words are as follows:
  - Register 1 reads 0x7809, with bit 2 = `link_up`, bit 5 = `an_complete` and bit 6 = preamble suppression enable.
  - Registers 2 and 3 read the ID_HI and ID_LO parameters.
  - Register 5 reads `lp_ability`.
  - Register 6 reads {15'b0, `lp_an_able`}.
  - Register 16 reads {14'b0, `link_up`, `an_complete`}.
- R8: Register 4 resets to 0x01E1. Bits 15:5 are writable, and bits 4:0 always read 00001.
- R9: Registers 7 to 15, 18, 19 and 26 to 31 read 0. Writes to them change no register and no output.
- R10: Registers 20 to 25 are 16-bit counters of `err_evt`[0] to `err_evt`[5]. Each counter adds one for every clock cycle in which its strobe is high.
- R11: A counter holds at 0xFFFF instead of wrapping.
- R12: A read of a counter returns its value and clears it to zero. If a strobe arrives in the same cycle as the clear, the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data value driven during reads |
| mdio_oe | output | 1 | Output enable for the data line |
| repeater_mode | input | 1 | 1 = full address space, 0 = four-address window |
| phy_addr_strap | input | 5 | Strapped PHY address |
| link_up | input | 1 | Link status from the datapath |
| an_complete | input | 1 | Auto-negotiation finished |
| lp_ability | input | 16 | Link partner ability word |
| lp_an_able | input | 1 | Link partner supports auto-negotiation |
| err_evt | input | 6 | Error-event strobes, one per counter |
| ctl_soft_reset | output | 1 | Soft reset in progress |
| ctl_loopback | output | 1 | Loopback select |
| ctl_speed100 | output | 1 | 1 = 100 Mb/s |
| ctl_an_enable | output | 1 | Auto-negotiation enable |
| ctl_power_down | output | 1 | Low-power request |
| ctl_isolate | output | 1 | Isolate the MII |
| ctl_full_duplex | output | 1 | Full duplex select |

## Verification
The bench sweeps every PHY address in both strap modes, including a strap whose upper bits must be ignored in adapter mode. A decoder that compared all five bits, or only two, would answer the wrong frames. It sends a frame after exactly 31 and exactly 32 preamble ones; an off-by-one preamble counter lets the first through or rejects the second. It writes all ones to every reserved address and reads back the real registers, catching address decode that aliases. It holds one strobe for 65,537 cycles to expose a wrapping counter, and reads every counter twice to expose a missing clear-on-read. It times the soft-reset pulse and checks that the preamble-suppression bit survives the soft reset.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_START,
    FS_OP,
    FS_ADDR,
    FS_TURN,
    FS_DATA
  } frame_state_t;

  localparam int unsigned REG_AW = 5;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam logic [REG_AW-1:0] RA_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 5'd1;
  localparam logic [REG_AW-1:0] RA_IDHI = 5'd2;
  localparam logic [REG_AW-1:0] RA_IDLO = 5'd3;
  localparam logic [REG_AW-1:0] RA_ADV  = 5'd4;
  localparam logic [REG_AW-1:0] RA_LPA  = 5'd5;
  localparam logic [REG_AW-1:0] RA_EXP  = 5'd6;
  localparam logic [REG_AW-1:0] RA_VSTS = 5'd16;
  localparam logic [REG_AW-1:0] RA_VCTL = 5'd17;

  localparam int unsigned CB_SRST  = 15;
  localparam int unsigned CB_LOOP  = 14;
  localparam int unsigned CB_SPEED = 13;
  localparam int unsigned CB_ANEN  = 12;
  localparam int unsigned CB_PDN   = 11;
  localparam int unsigned CB_ISO   = 10;
  localparam int unsigned CB_DUP   = 8;

  localparam logic [15:0] CTRL_DEF   = 16'h3000;
  localparam logic [15:0] CTRL_WMASK = 16'h7D00;
  localparam logic [15:0] ADV_DEF    = 16'h01E1;
  localparam logic [15:0] ADV_WMASK  = 16'hFFE0;
  localparam logic [15:0] STAT_FIXED = 16'h7809;

endpackage

// File: rtl/mdio_sampler.sv
module mdio_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_i,
  output logic bit_stb,
  output logic bit_val
);
  logic [SYNC_STAGES:0]   mdc_sh;
  logic [SYNC_STAGES-1:0] dat_sh;
  logic                   mdc_rise;

  assign mdc_rise = mdc_sh[SYNC_STAGES-1] & ~mdc_sh[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sh  <= '0;
      dat_sh  <= '1;
      bit_stb <= 1'b0;
      bit_val <= 1'b1;
    end else begin
      mdc_sh  <= {mdc_sh[SYNC_STAGES-1:0], mdc};
      dat_sh  <= {dat_sh[SYNC_STAGES-2:0], mdio_i};
      bit_stb <= mdc_rise;
      bit_val <= dat_sh[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_slave_pkg::*;
#(
  parameter int unsigned DATA_W            = 16,
  parameter int unsigned PRE_LEN           = 32,
  parameter int unsigned ADAPTER_ADDR_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                pre_sup,
  input  logic                repeater_mode,
  input  logic [REG_AW-1:0]   phy_strap,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                rd_req,
  output logic                wr_req,
  output logic [REG_AW-1:0]   reg_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                mdio_o,
  output logic                mdio_oe
);
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned ONES_W = $clog2(PRE_LEN + 1);
  localparam int unsigned HDR_W  = 2 * REG_AW;
  localparam logic [REG_AW-1:0] AMASK = REG_AW'((1 << ADAPTER_ADDR_BITS) - 1);

  frame_state_t        st;
  logic [CNT_W-1:0]    cnt;
  logic [ONES_W-1:0]   ones;
  logic [1:0]          opc;
  logic [HDR_W-1:0]    hdr_sh;
  logic [HDR_W-1:0]    hdr_next;
  logic [DATA_W-1:0]   data_sh;
  logic                reading;
  logic                writing;
  logic                pa_hit;

  assign hdr_next = {hdr_sh[HDR_W-2:0], bit_val};

  always_comb begin
    if (repeater_mode) pa_hit = (hdr_next[HDR_W-1:REG_AW] == phy_strap);
    else               pa_hit = (hdr_next[HDR_W-1:REG_AW] == (phy_strap & AMASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_PRE;
      cnt      <= '0;
      ones     <= '0;
      opc      <= '0;
      hdr_sh   <= '0;
      data_sh  <= '0;
      reading  <= 1'b0;
      writing  <= 1'b0;
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      reg_addr <= '0;
      wr_data  <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      if (bit_stb) begin
        unique case (st)
          FS_PRE: begin
            if (bit_val) begin
              if (ones != ONES_W'(PRE_LEN)) ones <= ones + 1'b1;
            end else begin
              if (pre_sup || ones == ONES_W'(PRE_LEN)) st <= FS_START;
              ones <= '0;
            end
          end
          FS_START: begin
            cnt <= '0;
            st  <= bit_val ? FS_OP : FS_PRE;
          end
          FS_OP: begin
            opc <= {opc[0], bit_val};
            if (cnt == CNT_W'(1)) begin
              st  <= FS_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_ADDR: begin
            hdr_sh <= hdr_next;
            if (cnt == CNT_W'(HDR_W - 1)) begin
              reg_addr <= hdr_next[REG_AW-1:0];
              reading  <= pa_hit && (opc == OPC_READ);
              writing  <= pa_hit && (opc == OPC_WRITE);
              rd_req   <= pa_hit && (opc == OPC_READ);
              st       <= FS_TURN;
              cnt      <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_TURN: begin
            if (cnt == '0) begin
              cnt <= CNT_W'(1);
              if (reading) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt     <= '0;
              st      <= FS_DATA;
              data_sh <= {rd_data[DATA_W-2:0], 1'b0};
              if (reading) mdio_o <= rd_data[DATA_W-1];
            end
          end
          FS_DATA: begin
            if (reading) begin
              mdio_o  <= data_sh[DATA_W-1];
              data_sh <= {data_sh[DATA_W-2:0], 1'b0};
            end else begin
              data_sh <= {data_sh[DATA_W-2:0], bit_val};
            end
            if (cnt == CNT_W'(DATA_W - 1)) begin
              st   <= FS_PRE;
              ones <= '0;
              cnt  <= '0;
              if (reading) begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b1;
              end
              if (writing) begin
                wr_req  <= 1'b1;
                wr_data <= {data_sh[DATA_W-2:0], bit_val};
              end
              reading <= 1'b0;
              writing <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= FS_PRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_err_counter.sv
module mdio_err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                      q <= '0;
    else if (clr)                 q <= inc ? CNT_W'(1) : '0;
    else if (inc && q != CNT_MAX) q <= q + 1'b1;
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned N_CNT       = 6,
  parameter int unsigned CNT_BASE    = 20,
  parameter int unsigned SRST_CYCLES = 16,
  parameter logic [15:0] ID_HI       = 16'h0A5C,
  parameter logic [15:0] ID_LO       = 16'h7301
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic                wr_req,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                link_up,
  input  logic                an_complete,
  input  logic [15:0]         lp_ability,
  input  logic                lp_an_able,
  input  logic [N_CNT-1:0]    err_evt,
  output logic                pre_sup,
  output logic                ctl_soft_reset,
  output logic                ctl_loopback,
  output logic                ctl_speed100,
  output logic                ctl_an_enable,
  output logic                ctl_power_down,
  output logic                ctl_isolate,
  output logic                ctl_full_duplex
);
  localparam int unsigned SRST_W = $clog2(SRST_CYCLES + 1);

  logic [15:0]       ctrl_q;
  logic [15:0]       adv_q;
  logic              sup_q;
  logic              srst_active;
  logic [SRST_W-1:0] srst_cnt;
  logic [DATA_W-1:0] cnt_q [N_CNT];
  logic [DATA_W-1:0] rd_mux;

  genvar gi;
  generate
    for (gi = 0; gi < N_CNT; gi++) begin : g_cnt
      logic clr_i;
      assign clr_i = rd_req && (addr == REG_AW'(CNT_BASE + gi));
      mdio_err_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (err_evt[gi]),
        .clr (clr_i),
        .q   (cnt_q[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= CTRL_DEF;
      adv_q       <= ADV_DEF;
      sup_q       <= 1'b0;
      srst_active <= 1'b0;
      srst_cnt    <= '0;
    end else begin
      if (srst_active) begin
        ctrl_q <= CTRL_DEF;
        adv_q  <= ADV_DEF;
        if (srst_cnt == '0) srst_active <= 1'b0;
        else                srst_cnt    <= srst_cnt - 1'b1;
      end else if (wr_req) begin
        if (addr == RA_CTRL) begin
          if (wr_data[CB_SRST]) begin
            srst_active <= 1'b1;
            srst_cnt    <= SRST_W'(SRST_CYCLES - 1);
            ctrl_q      <= CTRL_DEF;
            adv_q       <= ADV_DEF;
          end else begin
            ctrl_q <= wr_data[15:0] & CTRL_WMASK;
          end
        end
        if (addr == RA_ADV)
          adv_q <= (wr_data[15:0] & ADV_WMASK) | (ADV_DEF & ~ADV_WMASK);
      end
      if (wr_req && addr == RA_VCTL) sup_q <= wr_data[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL: rd_mux = {srst_active, ctrl_q[14:0]};
      RA_STAT: begin
        rd_mux    = STAT_FIXED;
        rd_mux[2] = link_up;
        rd_mux[5] = an_complete;
        rd_mux[6] = sup_q;
      end
      RA_IDHI: rd_mux = ID_HI;
      RA_IDLO: rd_mux = ID_LO;
      RA_ADV:  rd_mux = adv_q;
      RA_LPA:  rd_mux = lp_ability;
      RA_EXP:  rd_mux = {{(DATA_W-1){1'b0}}, lp_an_able};
      RA_VSTS: rd_mux = {{(DATA_W-2){1'b0}}, link_up, an_complete};
      RA_VCTL: rd_mux = {{(DATA_W-1){1'b0}}, sup_q};
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < int'(N_CNT); i++) begin
      if (addr == REG_AW'(CNT_BASE + i)) rd_mux = cnt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_req) rd_data <= rd_mux;
  end

  assign pre_sup         = sup_q;
  assign ctl_soft_reset  = srst_active;
  assign ctl_loopback    = ctrl_q[CB_LOOP];
  assign ctl_speed100    = ctrl_q[CB_SPEED];
  assign ctl_an_enable   = ctrl_q[CB_ANEN];
  assign ctl_power_down  = ctrl_q[CB_PDN];
  assign ctl_isolate     = ctrl_q[CB_ISO];
  assign ctl_full_duplex = ctrl_q[CB_DUP];
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int unsigned DATA_W            = 16,
  parameter int unsigned PRE_LEN           = 32,
  parameter int unsigned ADAPTER_ADDR_BITS = 2,
  parameter int unsigned SYNC_STAGES       = 2,
  parameter int unsigned N_CNT             = 6,
  parameter int unsigned CNT_BASE          = 20,
  parameter int unsigned SRST_CYCLES       = 16,
  parameter logic [15:0] ID_HI             = 16'h0A5C,
  parameter logic [15:0] ID_LO             = 16'h7301
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              repeater_mode,
  input  logic [4:0]        phy_addr_strap,
  input  logic              link_up,
  input  logic              an_complete,
  input  logic [15:0]       lp_ability,
  input  logic              lp_an_able,
  input  logic [N_CNT-1:0]  err_evt,
  output logic              ctl_soft_reset,
  output logic              ctl_loopback,
  output logic              ctl_speed100,
  output logic              ctl_an_enable,
  output logic              ctl_power_down,
  output logic              ctl_isolate,
  output logic              ctl_full_duplex
);
  logic              bit_stb;
  logic              bit_val;
  logic              pre_sup;
  logic              rd_req;
  logic              wr_req;
  logic [REG_AW-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  mdio_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_i  (mdio_i),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  mdio_frame_engine #(
    .DATA_W            (DATA_W),
    .PRE_LEN           (PRE_LEN),
    .ADAPTER_ADDR_BITS (ADAPTER_ADDR_BITS)
  ) u_eng (
    .clk           (clk),
    .rst           (rst),
    .bit_stb       (bit_stb),
    .bit_val       (bit_val),
    .pre_sup       (pre_sup),
    .repeater_mode (repeater_mode),
    .phy_strap     (phy_addr_strap),
    .rd_data       (rd_data),
    .rd_req        (rd_req),
    .wr_req        (wr_req),
    .reg_addr      (reg_addr),
    .wr_data       (wr_data),
    .mdio_o        (mdio_o),
    .mdio_oe       (mdio_oe)
  );

  mdio_regfile #(
    .DATA_W      (DATA_W),
    .N_CNT       (N_CNT),
    .CNT_BASE    (CNT_BASE),
    .SRST_CYCLES (SRST_CYCLES),
    .ID_HI       (ID_HI),
    .ID_LO       (ID_LO)
  ) u_regs (
    .clk             (clk),
    .rst             (rst),
    .rd_req          (rd_req),
    .wr_req          (wr_req),
    .addr            (reg_addr),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .link_up         (link_up),
    .an_complete     (an_complete),
    .lp_ability      (lp_ability),
    .lp_an_able      (lp_an_able),
    .err_evt         (err_evt),
    .pre_sup         (pre_sup),
    .ctl_soft_reset  (ctl_soft_reset),
    .ctl_loopback    (ctl_loopback),
    .ctl_speed100    (ctl_speed100),
    .ctl_an_enable   (ctl_an_enable),
    .ctl_power_down  (ctl_power_down),
    .ctl_isolate     (ctl_isolate),
    .ctl_full_duplex (ctl_full_duplex)
  );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SRST_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic ctl_soft_reset,
  input logic ctl_loopback,
  input logic ctl_speed100,
  input logic ctl_an_enable,
  input logic ctl_power_down,
  input logic ctl_isolate,
  input logic ctl_full_duplex
);
  logic        mdc_q;
  int unsigned drive_rises;
  int unsigned srst_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q       <= 1'b0;
      drive_rises <= 0;
      srst_len    <= 0;
    end else begin
      mdc_q <= mdc;
      if (!mdio_oe)          drive_rises <= 0;
      else if (mdc && !mdc_q) drive_rises <= drive_rises + 1;
      if (ctl_soft_reset) srst_len <= srst_len + 1;
      else                srst_len <= 0;
    end
  end

  AST_TURN_DRIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o); // R2

  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> drive_rises <= DATA_W + 1); // R2

  AST_SRST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    ctl_soft_reset |-> srst_len < SRST_CYCLES); // R6

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    ctl_soft_reset |-> (ctl_speed100 && ctl_an_enable && !ctl_power_down &&
                        !ctl_isolate && !ctl_full_duplex && !ctl_loopback)); // R6

  AST_SRST_ENDS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_soft_reset) |-> (ctl_speed100 && !ctl_power_down && !ctl_isolate)); // R6
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
  .DATA_W      (DATA_W),
  .SRST_CYCLES (SRST_CYCLES)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .mdc             (mdc),
  .mdio_o          (mdio_o),
  .mdio_oe         (mdio_oe),
  .ctl_soft_reset  (ctl_soft_reset),
  .ctl_loopback    (ctl_loopback),
  .ctl_speed100    (ctl_speed100),
  .ctl_an_enable   (ctl_an_enable),
  .ctl_power_down  (ctl_power_down),
  .ctl_isolate     (ctl_isolate),
  .ctl_full_duplex (ctl_full_duplex)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WDOG       = 195000;
  localparam logic [15:0] EXP_ID_HI = 16'h0A5C;
  localparam logic [15:0] EXP_ID_LO = 16'h7301;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        m_en = 1'b0;
  logic        m_val = 1'b1;
  logic        line;
  logic        mdio_o, mdio_oe;
  logic        repeater_mode = 1'b0;
  logic [4:0]  phy_addr_strap = 5'b10110;
  logic        link_up = 1'b1;
  logic        an_complete = 1'b0;
  logic [15:0] lp_ability = 16'hC5E1;
  logic        lp_an_able = 1'b1;
  logic [5:0]  err_evt = '0;
  logic        ctl_soft_reset, ctl_loopback, ctl_speed100, ctl_an_enable;
  logic        ctl_power_down, ctl_isolate, ctl_full_duplex;

  int n_chk  = 0;
  int n_fail = 0;
  int tb_pre = 32;
  int srst_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  always @(posedge clk) if (ctl_soft_reset) srst_hi <= srst_hi + 1;

  mdio_mgmt_slave dut (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .repeater_mode(repeater_mode), .phy_addr_strap(phy_addr_strap),
    .link_up(link_up), .an_complete(an_complete), .lp_ability(lp_ability),
    .lp_an_able(lp_an_able), .err_evt(err_evt),
    .ctl_soft_reset(ctl_soft_reset), .ctl_loopback(ctl_loopback),
    .ctl_speed100(ctl_speed100), .ctl_an_enable(ctl_an_enable),
    .ctl_power_down(ctl_power_down), .ctl_isolate(ctl_isolate),
    .ctl_full_duplex(ctl_full_duplex)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic en, input logic v, output logic s_oe, output logic s_line);
    mdc = 1'b0; m_en = en; m_val = v;
    repeat (HALF) @(negedge clk);
    s_oe = mdio_oe; s_line = line;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic mframe(input bit lead0, input int npre, input logic [1:0] op,
                        input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                        output logic [15:0] rdv, output bit resp,
                        output bit ta_ok, output bit rel_ok);
    logic so, sl;
    rdv = '1; resp = 0; ta_ok = 1; rel_ok = 1;
    if (lead0) send_bit(1'b1, 1'b0, so, sl);
    for (int i = 0; i < npre; i++) send_bit(1'b1, 1'b1, so, sl);
    send_bit(1'b1, 1'b0, so, sl);
    send_bit(1'b1, 1'b1, so, sl);
    for (int i = 1; i >= 0; i--) send_bit(1'b1, op[i], so, sl);
    for (int i = 4; i >= 0; i--) send_bit(1'b1, pa[i], so, sl);
    for (int i = 4; i >= 0; i--) send_bit(1'b1, ra[i], so, sl);
    if (op == 2'b10) begin
      send_bit(1'b0, 1'b1, so, sl);
      ta_ok = !so;
      send_bit(1'b0, 1'b1, so, sl);
      resp = so && !sl;
      for (int i = 15; i >= 0; i--) begin
        send_bit(1'b0, 1'b1, so, sl);
        rdv[i] = sl;
      end
    end else begin
      send_bit(1'b1, 1'b1, so, sl);
      send_bit(1'b1, 1'b0, so, sl);
      for (int i = 15; i >= 0; i--) send_bit(1'b1, wd[i], so, sl);
    end
    send_bit(1'b0, 1'b1, so, sl);
    rel_ok = !so;
  endtask

  task automatic rd(input logic [4:0] pa, input logic [4:0] ra,
                    output logic [15:0] v, output bit resp);
    bit ta_ok, rel_ok;
    mframe(1'b0, tb_pre, 2'b10, pa, ra, 16'h0, v, resp, ta_ok, rel_ok);
    chk("R2 turnaround bit one released", {15'b0, ta_ok}, 16'h1);
    chk("R2 line released after data", {15'b0, rel_ok}, 16'h1);
  endtask

  task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] v; bit r, t, l;
    mframe(1'b0, tb_pre, 2'b01, pa, ra, d, v, r, t, l);
  endtask

  task automatic rd_exp(input string req, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] v; bit r;
    rd(5'd2, ra, v, r);
    chk(req, {15'b0, r}, 16'h1);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v; bit r, t, l;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R5 reset state of control outputs
    chk("R5 reset outputs",
        {9'b0, ctl_soft_reset, ctl_loopback, ctl_speed100, ctl_an_enable,
         ctl_power_down, ctl_isolate, ctl_full_duplex}, 16'h0018);
    chk("R2 reset oe", {15'b0, mdio_oe}, 16'h0);

    // R1 R2 basic reads
    rd_exp("R1 read id high", 5'd2, EXP_ID_HI);
    rd_exp("R7 read id low", 5'd3, EXP_ID_LO);

    // R4 preamble length boundary
    mframe(1'b1, 31, 2'b10, 5'd2, 5'd2, 16'h0, v, r, t, l);
    chk("R4 31 ones rejected", {15'b0, r}, 16'h0);
    mframe(1'b1, 32, 2'b10, 5'd2, 5'd2, 16'h0, v, r, t, l);
    chk("R4 32 ones accepted", {15'b0, r}, 16'h1);
    chk("R4 32 ones data", v, EXP_ID_HI);

    // R7 read-only words
    rd_exp("R7 status", 5'd1, 16'h780D);
    rd_exp("R7 link partner", 5'd5, 16'hC5E1);
    rd_exp("R7 expansion", 5'd6, 16'h0001);
    rd_exp("R7 vendor status", 5'd16, 16'h0002);
    rd_exp("R5 control default", 5'd0, 16'h3000);
    rd_exp("R8 adv default", 5'd4, 16'h01E1);

    // R4 preamble suppression
    wr(5'd2, 5'd17, 16'hFFFF);
    rd_exp("R4 vendor control", 5'd17, 16'h0001);
    tb_pre = 0;
    rd_exp("R4 no preamble accepted", 5'd3, EXP_ID_LO);
    an_complete = 1'b1;
    rd_exp("R7 status with sup and an", 5'd1, 16'h786D);

    // R3 adapter mode sweep, strap upper bits ignored
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), 5'd2, v, r);
      chk("R3 adapter sweep", {15'b0, r}, (a == 2) ? 16'h1 : 16'h0);
    end

    // R1 invalid opcodes
    mframe(1'b0, 0, 2'b11, 5'd2, 5'd2, 16'h0, v, r, t, l);
    chk("R1 opcode 11 no drive", {15'b0, l}, 16'h1);
    mframe(1'b0, 0, 2'b00, 5'd2, 5'd0, 16'h0800, v, r, t, l);
    chk("R1 opcode 00 no write", {15'b0, ctl_power_down}, 16'h0);
    rd_exp("R1 control unchanged", 5'd0, 16'h3000);

    // R5 control writes
    wr(5'd2, 5'd0, 16'h7FFF);
    chk("R5 outputs all set",
        {10'b0, ctl_loopback, ctl_speed100, ctl_an_enable,
         ctl_power_down, ctl_isolate, ctl_full_duplex}, 16'h003F);
    rd_exp("R5 control readback", 5'd0, 16'h7D00);
    wr(5'd2, 5'd0, 16'h0000);
    chk("R5 outputs cleared",
        {10'b0, ctl_loopback, ctl_speed100, ctl_an_enable,
         ctl_power_down, ctl_isolate, ctl_full_duplex}, 16'h0000);

    // R8 advertisement
    wr(5'd2, 5'd4, 16'hFFFF);
    rd_exp("R8 adv all ones", 5'd4, 16'hFFE1);
    wr(5'd2, 5'd4, 16'h0000);
    rd_exp("R8 adv zeros", 5'd4, 16'h0001);

    // R9 reserved addresses
    for (int a = 7; a < 32; a++) begin
      if (a <= 15 || a == 18 || a == 19 || a >= 26) begin
        wr(5'd2, 5'(a), 16'hFFFF);
        rd_exp("R9 reserved reads zero", 5'(a), 16'h0000);
      end
    end
    rd_exp("R9 control untouched", 5'd0, 16'h0000);
    rd_exp("R9 adv untouched", 5'd4, 16'h0001);
    chk("R9 outputs untouched",
        {10'b0, ctl_loopback, ctl_speed100, ctl_an_enable,
         ctl_power_down, ctl_isolate, ctl_full_duplex}, 16'h0000);

    // R6 soft reset
    wr(5'd2, 5'd0, 16'h0D00);
    wr(5'd2, 5'd4, 16'h0020);
    srst_hi = 0;
    wr(5'd2, 5'd0, 16'h8000);
    repeat (40) @(negedge clk);
    chk("R6 soft reset length", 16'(srst_hi), 16'd16);
    chk("R6 soft reset cleared", {15'b0, ctl_soft_reset}, 16'h0);
    rd_exp("R6 control default", 5'd0, 16'h3000);
    rd_exp("R6 adv default", 5'd4, 16'h01E1);
    rd_exp("R6 vendor control kept", 5'd17, 16'h0001);

    // R10 R12 counters
    for (int i = 0; i < 6; i++) begin
      err_evt[i] = 1'b1;
      repeat (3*i + 2) @(negedge clk);
      err_evt[i] = 1'b0;
    end
    for (int i = 0; i < 6; i++) rd_exp("R10 counter value", 5'(20 + i), 16'(3*i + 2));
    for (int i = 0; i < 6; i++) rd_exp("R12 cleared on read", 5'(20 + i), 16'h0000);

    // R11 saturation
    err_evt[5] = 1'b1;
    repeat (65537) @(negedge clk);
    err_evt[5] = 1'b0;
    rd_exp("R11 saturated", 5'd25, 16'hFFFF);
    rd_exp("R12 cleared after saturation", 5'd25, 16'h0000);

    // R3 repeater mode sweep
    repeater_mode = 1'b1;
    phy_addr_strap = 5'd21;
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), 5'd3, v, r);
      chk("R3 repeater sweep", {15'b0, r}, (a == 21) ? 16'h1 : 16'h0);
      if (a == 21) chk("R3 repeater data", v, EXP_ID_LO);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule